// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Single-Character Buffers

This block is a byte-wide asynchronous serial port behind an APB slave. Software writes a character into a one-entry transmit holding buffer and reads received characters from a one-entry receive holding buffer; there is no FIFO on either side. A shifter serializes the held character onto `txd_o` as one start bit, eight data bits least significant first, and one stop bit. A deserializer recovers characters from `rxd_i` with the same framing. Each bit lasts a programmable number of clock cycles.

Overruns on either side are recorded in sticky flags. Five interrupt lines report transmit hand-off, receive, transmit overrun, receive overrun, and the OR of those four. The two overrun interrupt bits are not stored: they are computed each cycle from the overrun flags and their enables, so clearing either copy clears both.

Top module: `sport_apb`

## Requirements
- R1: Word offsets: 0x000 data, 0x004 status, 0x008 control, 0x00C interrupt, 0x010 divisor. Offsets 0xFD0 to 0xFFC are a read-only identification window whose byte reads 0xA0 + (offset - 0xFD0)/4. Any other offset reads 0, and writes to it or to the window change nothing.
- R2: After reset every register and both holding buffers are 0, `txd_o` is high and all interrupt outputs are low.
- R3: Control keeps write-data bits 6:0 and discards the rest: bit 0 transmit enable, bit 1 receive enable, bit 2 transmit interrupt enable, bit 3 receive interrupt enable, bit 4 transmit-overrun interrupt enable, bit 5 receive-overrun interrupt enable, bit 6 a stored test bit. The divisor keeps write-data bits 19:0.
- R4: A data write while status bit 0 (transmit full) is clear loads the buffer and sets bit 0. A data write while bit 0 is set replaces the held character and sets status bit 2 (transmit overrun), and the replacement is the character that goes out.
- R5: Transmission of the held character starts when transmit is enabled, the buffer is full, the divisor is at least 16 and the shifter is idle. The start clears transmit full, and the line carries low, the 8 data bits LSB first and a high stop bit, each for divisor cycles, idling high otherwise.
- R6: When transmit full falls and the transmit interrupt enable is 1, interrupt bit 0 is set. It stays set until a 1 is written to interrupt bit 0.
- R7: An accepted character sets status bit 1 (receive full), and sets interrupt bit 1 if the receive interrupt enable is 1 (cleared by writing 1 to it). A data read returns the character and clears receive full.
- R8: A character that completes while receive is disabled is discarded: the buffer, status and interrupts are unchanged.
- R9: A character accepted while receive full is set sets status bit 3 (receive overrun) and replaces the held character.
- R10: Writing 1 to status bit 2 or bit 3 clears that overrun flag. Status bits 0 and 1 ignore writes.
- R11: Interrupt bits 2 and 3 read as the transmit/receive overrun flag ANDed with control bit 4/5 respectively. Writing 1 to either clears the underlying status flag.
- R12: `irq_tx_o`, `irq_rx_o`, `irq_txovr_o`, `irq_rxovr_o` follow interrupt bits 0 to 3, and `irq_any_o` is high when any of them is.
- R13: A data write in the same cycle a transmission takes the held character leaves transmit full set and raises no transmit overrun. A data read in the same cycle a character is accepted returns the old character, leaves receive full set and raises no receive overrun.
- R14: While the divisor is below 16 no transmission starts and `txd_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and bit-timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| irq_tx_o | output | 1 | Transmit hand-off interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_txovr_o | output | 1 | Transmit overrun interrupt |
| irq_rxovr_o | output | 1 | Receive overrun interrupt |
| irq_any_o | output | 1 | OR of the four interrupts |

## Verification
The two functions that can collide are a data read from software and the receiver completing a character, both of which act on the receive-full flag and the overrun flag. The bench holds an unread character, sends a second one on `rxd_i`, and starts the data read at a sweep of cycle offsets that covers the stop-bit sample on both sides, so one offset lands in the acceptance cycle. Every offset is judged on the same rule: if the read returned the old character, receive full must still be set with no overrun and the next read must return the new character; if it returned the new one, the overrun flag must be set. The matching transmit collision, a data write in the hand-off cycle, is covered by a property.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int ADDR_W  = 12;
  localparam int WORD_W  = 32;
  localparam int CHAR_W  = 8;
  localparam int DIV_W   = 20;
  localparam int MIN_DIV = 16;
  localparam int CTRL_W  = 7;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_INT   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ID_LO = 12'hFD0;
  localparam logic [7:0]        ID_BASE   = 8'hA0;

  // bit 0 is the last member
  typedef struct packed {
    logic test;
    logic rxo_ie;
    logic txo_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] d;
    d = a - OFS_ID_LO;
    return ID_BASE + 8'(d[ADDR_W-1:2]);
  endfunction
endpackage

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int DIV_W = 20,
  parameter int BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [BITS-1:0]  data_i,
  output logic             busy_o,
  output logic             txd_o
);
  localparam int LEFT_W = $clog2(BITS + 2);

  logic [DIV_W-1:0]  div_q, cnt_q;
  logic [BITS:0]     sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              busy_q, txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      sh_q   <= {1'b1, data_i};
      left_q <= LEFT_W'(BITS + 1);
      div_q  <= div_i;
      cnt_q  <= div_i - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[BITS:1]};
          left_q <= left_q - 1'b1;
          cnt_q  <= div_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int DIV_W = 20,
  parameter int BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic [BITS-1:0]  data_o
);
  localparam int IDX_W = $clog2(BITS + 2);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(BITS + 1);

  logic [2:0]       sync_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [BITS-1:0]  sh_q;
  logic             busy_q;
  logic             line, fall;

  assign line = sync_q[1];
  assign fall = sync_q[2] && !sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      div_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd_i};
      if (!busy_q) begin
        if (en_i && fall) begin
          busy_q <= 1'b1;
          div_q  <= div_i;
          cnt_q  <= (div_i >> 1) - 1'b1;
          idx_q  <= '0;
        end
      end else if (cnt_q == '0) begin
        cnt_q <= div_q - 1'b1;
        idx_q <= idx_q + 1'b1;
        if (idx_q == '0 && line) busy_q <= 1'b0;  // glitch, not a start bit
        else if (idx_q == IDX_STOP) busy_q <= 1'b0;
        else if (idx_q != '0) sh_q <= {line, sh_q[BITS-1:1]};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done_o = busy_q && (cnt_q == '0) && (idx_q == IDX_STOP);
  assign data_o = sh_q;
endmodule

// File: rtl/sport_apb.sv
module sport_apb
  import sport_pkg::*;
#(
  parameter int DIV_BITS = sport_pkg::DIV_W,
  parameter int DIV_MIN  = sport_pkg::MIN_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [WORD_W-1:0] pwdata_i,
  output logic [WORD_W-1:0] prdata_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_txovr_o,
  output logic              irq_rxovr_o,
  output logic              irq_any_o
);
  ctrl_t               ctrl_q;
  logic [DIV_BITS-1:0] div_q;
  logic [CHAR_W-1:0]   txbuf_q, rxbuf_q, rx_data;
  logic                txfull_q, rxfull_q, txovr_q, rxovr_q, tx_is_q, rx_is_q;
  logic                acc, wr_data, wr_stat, wr_ctrl, wr_int, wr_div, rd_data;
  logic                baud_ok, tx_busy, tx_start, rx_done, rx_acc;
  logic [3:0]          int_vec;
  logic                unused_bits;

  assign acc     = psel_i && penable_i;
  assign wr_data = acc && pwrite_i && (paddr_i == OFS_DATA);
  assign wr_stat = acc && pwrite_i && (paddr_i == OFS_STAT);
  assign wr_ctrl = acc && pwrite_i && (paddr_i == OFS_CTRL);
  assign wr_int  = acc && pwrite_i && (paddr_i == OFS_INT);
  assign wr_div  = acc && pwrite_i && (paddr_i == OFS_DIV);
  assign rd_data = acc && !pwrite_i && (paddr_i == OFS_DATA);
  assign unused_bits = ^pwdata_i[WORD_W-1:DIV_BITS];

  assign baud_ok  = div_q >= DIV_BITS'(DIV_MIN);
  assign tx_start = ctrl_q.tx_en && txfull_q && baud_ok && !tx_busy;
  assign rx_acc   = rx_done && ctrl_q.rx_en;

  sport_tx #(.DIV_W(DIV_BITS), .BITS(CHAR_W)) u_tx (
    .clk_i, .rst_ni, .div_i(div_q), .start_i(tx_start), .data_i(txbuf_q),
    .busy_o(tx_busy), .txd_o
  );

  sport_rx #(.DIV_W(DIV_BITS), .BITS(CHAR_W)) u_rx (
    .clk_i, .rst_ni, .div_i(div_q), .en_i(baud_ok), .rxd_i,
    .done_o(rx_done), .data_o(rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      txbuf_q  <= '0;
      rxbuf_q  <= '0;
      txfull_q <= 1'b0;
      rxfull_q <= 1'b0;
      txovr_q  <= 1'b0;
      rxovr_q  <= 1'b0;
      tx_is_q  <= 1'b0;
      rx_is_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(pwdata_i[CTRL_W-1:0]);
      if (wr_div)  div_q  <= pwdata_i[DIV_BITS-1:0];

      // transmit side: a write in the hand-off cycle refills the buffer
      if (wr_data) begin
        txbuf_q  <= pwdata_i[CHAR_W-1:0];
        txfull_q <= 1'b1;
      end else if (tx_start) begin
        txfull_q <= 1'b0;
      end
      if (wr_data && txfull_q && !tx_start)           txovr_q <= 1'b1;
      else if ((wr_stat || wr_int) && pwdata_i[2])    txovr_q <= 1'b0;
      if (tx_start && !wr_data && ctrl_q.tx_ie)       tx_is_q <= 1'b1;
      else if (wr_int && pwdata_i[0])                 tx_is_q <= 1'b0;

      // receive side: a read in the acceptance cycle frees the buffer
      if (rx_acc) begin
        rxbuf_q  <= rx_data;
        rxfull_q <= 1'b1;
      end else if (rd_data) begin
        rxfull_q <= 1'b0;
      end
      if (rx_acc && rxfull_q && !rd_data)             rxovr_q <= 1'b1;
      else if ((wr_stat || wr_int) && pwdata_i[3])    rxovr_q <= 1'b0;
      if (rx_acc && ctrl_q.rx_ie)                     rx_is_q <= 1'b1;
      else if (wr_int && pwdata_i[1])                 rx_is_q <= 1'b0;
    end
  end

  assign int_vec = {rxovr_q && ctrl_q.rxo_ie, txovr_q && ctrl_q.txo_ie, rx_is_q, tx_is_q};

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      OFS_DATA: prdata_o = WORD_W'(rxbuf_q);
      OFS_STAT: prdata_o = WORD_W'({rxovr_q, txovr_q, rxfull_q, txfull_q});
      OFS_CTRL: prdata_o = WORD_W'(ctrl_q);
      OFS_INT:  prdata_o = WORD_W'(int_vec);
      OFS_DIV:  prdata_o = WORD_W'(div_q);
      default:
        if (paddr_i >= OFS_ID_LO && paddr_i[1:0] == 2'b00)
          prdata_o = WORD_W'(id_byte(paddr_i));
    endcase
  end

  assign irq_tx_o    = int_vec[0];
  assign irq_rx_o    = int_vec[1];
  assign irq_txovr_o = int_vec[2];
  assign irq_rxovr_o = int_vec[3];
  assign irq_any_o   = |int_vec;
endmodule

// File: rtl/sport_apb_chk.sv
module sport_apb_chk #(
  parameter int DIV_BITS = 20,
  parameter int DIV_MIN  = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_data,
  input logic                rd_data,
  input logic                wr_int,
  input logic [31:0]         pwdata_i,
  input logic [6:0]          ctrl_q,
  input logic [DIV_BITS-1:0] div_q,
  input logic                tx_start,
  input logic                tx_busy,
  input logic                txfull_q,
  input logic                txovr_q,
  input logic                rx_done,
  input logic [7:0]          rxbuf_q,
  input logic                rxfull_q,
  input logic                txd_o,
  input logic                irq_tx_o,
  input logic                irq_txovr_o
);
  assert_tx_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && txfull_q && !tx_start |=> txovr_q);

  assert_tx_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start && !wr_data && ctrl_q[2] |=> irq_tx_o);

  assert_read_frees_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && !(rx_done && ctrl_q[1]) |=> !rxfull_q);

  assert_rx_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && !ctrl_q[1] |=> $stable(rxbuf_q));

  assert_ovr_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_int && pwdata_i[2] && !(wr_data && txfull_q && !tx_start) |=> !irq_txovr_o);

  assert_handoff_collide_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && txfull_q && tx_start && !txovr_q |=> txfull_q && !txovr_q);

  assert_no_start_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q < DIV_BITS'(DIV_MIN)) && !tx_busy |=> txd_o);
endmodule

bind sport_apb sport_apb_chk #(.DIV_BITS(DIV_BITS), .DIV_MIN(DIV_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_data(wr_data), .rd_data(rd_data),
  .wr_int(wr_int), .pwdata_i(pwdata_i), .ctrl_q(ctrl_q), .div_q(div_q),
  .tx_start(tx_start), .tx_busy(tx_busy), .txfull_q(txfull_q), .txovr_q(txovr_q),
  .rx_done(rx_done), .rxbuf_q(rxbuf_q), .rxfull_q(rxfull_q), .txd_o(txd_o),
  .irq_tx_o(irq_tx_o), .irq_txovr_o(irq_txovr_o)
);

// File: tb/sport_apb_test.sv
module sport_apb_test;
  localparam int DIV = 16;
  localparam logic [11:0] A_DATA = 12'h000, A_STAT = 12'h004, A_CTRL = 12'h008,
                          A_INT = 12'h00C, A_DIV = 12'h010;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        txd, rxd = 1'b1;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
  int          checks = 0, errors = 0;

  sport_apb uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .txd_o(txd), .rxd_i(rxd),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_txovr_o(irq_txovr),
    .irq_rxovr_o(irq_rxovr), .irq_any_o(irq_any)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic capture_tx(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    int wait_n;
    b = '0;
    wait_n = 0;
    while (txd === 1'b1 && wait_n < 4000) begin
      @(negedge clk); wait_n++;
    end
    chk({tag, " start bit seen"}, 32'(txd), 32'd0);
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txd;
    end
    chk({tag, " frame data"}, 32'(b), 32'(exp));
    repeat (DIV) @(negedge clk);
    chk({tag, " stop bit"}, 32'(txd), 32'd1);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 txd idle", 32'(txd), 32'd1);
    chk("R2 irqs low", 32'({irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any}), 32'd0);
    rd_chk("R2 status", A_STAT, 32'd0);
    rd_chk("R2 control", A_CTRL, 32'd0);
    rd_chk("R2 interrupt", A_INT, 32'd0);
    rd_chk("R2 divisor", A_DIV, 32'd0);
    rd_chk("R2 data", A_DATA, 32'd0);
  endtask

  task automatic t_regs;
    apb_wr(A_CTRL, 32'hFFFF_FFC0);
    rd_chk("R3 control upper discarded", A_CTRL, 32'h40);
    apb_wr(A_CTRL, 32'h0);
    apb_wr(A_DIV, 32'hFFFF_FFFF);
    rd_chk("R3 divisor 20 bits", A_DIV, 32'h000F_FFFF);
    apb_wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R1 unmapped reads zero", 12'h020, 32'd0);
    rd_chk("R1 unmapped write harmless", A_CTRL, 32'h0);
    rd_chk("R1 id first", 12'hFD0, 32'hA0);
    apb_wr(12'hFFC, 32'h0);
    rd_chk("R1 id last read-only", 12'hFFC, 32'hAB);
  endtask

  task automatic t_bad_divisor;
    int lows;
    lows = 0;
    apb_wr(A_DIV, 32'd8);
    apb_wr(A_CTRL, 32'h1);
    apb_wr(A_DATA, 32'h55);
    repeat (300) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R14 line stays idle", 32'(lows), 32'd0);
    rd_chk("R14 buffer still held", A_STAT, 32'h1);
    apb_wr(A_DIV, DIV);
    capture_tx("R5 after divisor fixed", 8'h55);
    rd_chk("R5 buffer released", A_STAT, 32'h0);
    chk("R6 no irq when disabled", 32'(irq_tx), 32'd0);
  endtask

  task automatic t_tx;
    apb_wr(A_CTRL, 32'h15);
    apb_wr(A_DATA, 32'h3C);
    capture_tx("R5 frame", 8'h3C);
    chk("R6 tx irq", 32'(irq_tx), 32'd1);
    chk("R12 any follows tx", 32'(irq_any), 32'd1);
    apb_wr(A_INT, 32'h1);
    chk("R6 tx irq cleared", 32'(irq_tx), 32'd0);
    apb_wr(A_CTRL, 32'h14);
    apb_wr(A_DATA, 32'h11);
    rd_chk("R4 full set", A_STAT, 32'h1);
    apb_wr(A_DATA, 32'h99);
    rd_chk("R4 overrun", A_STAT, 32'h5);
    chk("R12 txovr irq", 32'({irq_txovr, irq_any}), 32'b11);
    rd_chk("R11 live overrun bit", A_INT, 32'h4);
    apb_wr(A_STAT, 32'h3);
    rd_chk("R10 full bits read-only", A_STAT, 32'h5);
    apb_wr(A_INT, 32'h4);
    rd_chk("R11 interrupt write clears flag", A_STAT, 32'h1);
    chk("R12 any low", 32'(irq_any), 32'd0);
    apb_wr(A_CTRL, 32'h15);
    capture_tx("R4 replacement sent", 8'h99);
    apb_wr(A_INT, 32'h1);
    apb_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_rx;
    apb_wr(A_CTRL, 32'h2A);
    send_rx(8'hA5);
    rd_chk("R7 full", A_STAT, 32'h2);
    chk("R7 rx irq", 32'({irq_rx, irq_any}), 32'b11);
    rd_chk("R7 data", A_DATA, 32'hA5);
    rd_chk("R7 read frees", A_STAT, 32'h0);
    apb_wr(A_INT, 32'h2);
    chk("R7 rx irq cleared", 32'(irq_rx), 32'd0);
    send_rx(8'h11);
    send_rx(8'h22);
    rd_chk("R9 overrun", A_STAT, 32'hA);
    chk("R12 rxovr irq", 32'(irq_rxovr), 32'd1);
    apb_wr(A_CTRL, 32'h0A);
    rd_chk("R11 masked overrun", A_INT, 32'h2);
    apb_wr(A_CTRL, 32'h2A);
    rd_chk("R11 unmasked overrun", A_INT, 32'hA);
    rd_chk("R9 newest kept", A_DATA, 32'h22);
    apb_wr(A_STAT, 32'h8);
    rd_chk("R10 status clear", A_STAT, 32'h0);
    apb_wr(A_INT, 32'h2);
  endtask

  task automatic t_rx_off;
    apb_wr(A_CTRL, 32'h28);
    send_rx(8'h77);
    rd_chk("R8 not accepted", A_STAT, 32'h0);
    chk("R8 no irq", 32'(irq_rx), 32'd0);
    rd_chk("R8 buffer kept", A_DATA, 32'h22);
  endtask

  task automatic t_collide;
    logic [31:0] d, s;
    logic [7:0]  old_c, new_c;
    apb_wr(A_CTRL, 32'h2A);
    for (int k = 140; k < 166; k++) begin
      old_c = 8'(k);
      new_c = ~old_c;
      send_rx(old_c);
      fork
        send_rx(new_c);
        begin
          repeat (k) @(negedge clk);
          apb_rd(A_DATA, d);
        end
      join
      repeat (4) @(negedge clk);
      apb_rd(A_STAT, s);
      if (d[7:0] == old_c) begin
        chk("R13 read wins, full kept", s, 32'h2);
        rd_chk("R13 new char held", A_DATA, 32'(new_c));
      end else begin
        chk("R9 late read sees new", d, 32'(new_c));
        chk("R9 late read overrun", s, 32'h8);
      end
      apb_wr(A_STAT, 32'h8);
      apb_wr(A_INT, 32'h2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_bad_divisor();
    t_tx();
    t_rx();
    t_rx_off();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule